// File: doc/BRIEF.md
# Synchronizing I2C Clock-Line Generator

This block produces the serial clock for an I2C master that shares an open-drain, wired-AND clock line with other devices. It has a single output that either pulls the line low or lets it go. It watches the resolved line level through a two-flop synchronizer and times its own low and high phases in ticks of a divided-down module clock. Any device that pulls the line low wins. The generator follows this in two ways. When it sees the line fall, it restarts its own low phase. After its own low time has run out, it does not begin a high phase until it sees the line actually high. As a result, the longest low period on the bus and the shortest high period on the bus set the shared clock.

A slave may hold the line low to stretch the clock for as long as it needs; the generator waits with no timeout. Two single-cycle strobes mark the first cycle of each low phase (where SDA may change) and of each high phase (where SDA is sampled) for the data logic. One prescaler and count combination is known to let data move while the clock is high. The block flags it and refuses to drive the line while it is selected.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted, and from the first clock edge after `en` goes low, `scl_drive_low`, `cfg_fault`, `rise_tick` and `fall_tick` are all 0.
- R2: The prescaler divides the system clock by `psc`+1. Phase counters advance only on the divided enable. Running alone, the line stays low for 3 + L×(`psc`+1) cycles, where L is `low_cnt`. The 3 cycles are synchronizer and edge-detect latency.
- R3: Running alone, the line stays high for 3 + H×(`psc`+1) cycles, where H is `high_cnt`. The full period is the sum of the low time and the high time.
- R4: After its own low count expires, the block releases the line and starts no high count until the synchronized line is high. `rise_tick` appears in the cycle after the third rising clock edge following the line's release.
- R5: While another device holds the line low, the block waits indefinitely. It does not drive the line and emits no `rise_tick`.
- R6: If the line falls while the block is in its high phase, `fall_tick` appears in the cycle after the third rising clock edge. `scl_drive_low` then stays asserted for exactly L×(`psc`+1) cycles.
- R7: With `en` high and `psc`=2, `low_cnt`=2, `high_cnt`=2, `cfg_fault` is 1 from the next edge and the line is never driven. Changing any of the three values clears `cfg_fault` at the next edge and starts a low phase at that edge.
- R8: `fall_tick` is 1 for exactly the first cycle of each low phase, together with `scl_drive_low`. `rise_tick` is 1 for exactly the first cycle of each high phase. The two are never 1 in the same cycle.
- R9: A `low_cnt` or `high_cnt` of 0 behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low returns to idle and releases the line |
| psc | input | PSC_W | Prescaler value, divide by psc+1 |
| low_cnt | input | CNT_W | Low phase length in module-clock ticks |
| high_cnt | input | CNT_W | High phase length in module-clock ticks |
| scl_in | input | 1 | Resolved clock-line level |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| rise_tick | output | 1 | First cycle of a high phase (sample point) |
| fall_tick | output | 1 | First cycle of a low phase (change point) |
| cfg_fault | output | 1 | Illegal prescaler/count combination selected |

## Verification
The hard cases are the ones where another device acts on the line: a second master pulling it low in the middle of the generator's high phase, and a slave stretching the low phase for hundreds of cycles. Neither can occur with the generator alone. The bench therefore models the line as the wired-AND of the generator's output and a second open-drain driver under its own control. It times that driver to take the line partway into a measured high phase, overlapping the restart, or to hold it low long after the generator's own count has expired. It then checks the strobe timing and the phase lengths against formulas computed in the bench.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             cfg_fault
);

  localparam logic [PSC_W-1:0] BAD_PSC = PSC_W'(2);
  localparam logic [CNT_W-1:0] BAD_LO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] BAD_HI  = CNT_W'(2);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_WAIT, ST_HIGH} st_t;

  st_t              state, nxt;
  logic [PSC_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic             s1, s2, sp;
  logic             restart;
  logic             fault_q, rise_q, fall_q;

  wire illegal = (psc == BAD_PSC) && (low_cnt == BAD_LO) && (high_cnt == BAD_HI);
  wire tick    = (pcnt == psc);
  wire fell    = sp & ~s2;
  wire lo_last = ({1'b0, cnt} + 1'b1) >= {1'b0, low_cnt};
  wire hi_last = ({1'b0, cnt} + 1'b1) >= {1'b0, high_cnt};

  assign scl_drive_low = (state == ST_LOW);
  assign rise_tick     = rise_q;
  assign fall_tick     = fall_q;
  assign cfg_fault     = fault_q;

  always_comb begin
    nxt     = state;
    restart = 1'b0;
    unique case (state)
      ST_IDLE: begin
        restart = 1'b1;
        if (en && !illegal) nxt = ST_LOW;
      end
      ST_LOW: begin
        restart = fell | s2;
        if (!restart && tick && lo_last) begin
          nxt     = ST_WAIT;
          restart = 1'b1;
        end
      end
      ST_WAIT: begin
        restart = 1'b1;
        if (s2) nxt = ST_HIGH;
      end
      ST_HIGH: begin
        if (fell || (tick && hi_last)) begin
          nxt     = ST_LOW;
          restart = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (!en || illegal) begin
      nxt     = ST_IDLE;
      restart = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pcnt    <= '0;
      cnt     <= '0;
      s1      <= 1'b1;
      s2      <= 1'b1;
      sp      <= 1'b1;
      fault_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      s1      <= scl_in;
      s2      <= s1;
      sp      <= s2;
      state   <= nxt;
      fault_q <= en && illegal;
      rise_q  <= (nxt == ST_HIGH) && (state != ST_HIGH);
      fall_q  <= (nxt == ST_LOW) && (state != ST_LOW);
      if (restart) begin
        pcnt <= '0;
        cnt  <= '0;
      end else if (tick) begin
        pcnt <= '0;
        cnt  <= cnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !cfg_fault)); // R1
  AST_RISE_AFTER_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> ($past(s2) && $past(state == ST_WAIT))); // R4
  AST_STRETCH_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !s2) |=> !rise_tick); // R5
  AST_FAULT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |-> !scl_drive_low); // R7
  AST_FALL_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> scl_drive_low); // R8
  AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick)); // R8

endmodule

// File: tb/scl_clock_gen_tb_top.sv
module scl_clock_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] psc = '0, low_cnt = 8'd1, high_cnt = 8'd1;
  logic other_low = 1'b0;
  logic scl_drive_low, rise_tick, fall_tick, cfg_fault;
  wire  scl_line = !(scl_drive_low || other_low);

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_clock_gen #(.PSC_W(8), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .psc(psc), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .scl_in(scl_line), .scl_drive_low(scl_drive_low),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .cfg_fault(cfg_fault));

  function automatic int eff(int c);
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int exp_low(int p, int l);
    return 3 + eff(l) * (p + 1);
  endfunction
  function automatic int exp_high(int p, int h);
    return 3 + eff(h) * (p + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    int n = 0;
    while (!fall_tick && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R8 fall_tick timeout", 0, 1);
  endtask

  task automatic wait_rise();
    int n = 0;
    while (!rise_tick && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R8 rise_tick timeout", 0, 1);
  endtask

  task automatic measure(output int lo, output int hi, output int rise_at);
    lo = 0; hi = 0; rise_at = -1;
    while (!scl_line && lo < 5000) begin lo++; @(negedge clk); end
    while (scl_line && hi < 5000) begin
      if (rise_tick && rise_at < 0) rise_at = hi;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(int p, int l, int h, string tag);
    int lo, hi, ra;
    en = 1'b0;
    repeat (2) @(negedge clk);
    psc = 8'(p); low_cnt = 8'(l); high_cnt = 8'(h);
    en = 1'b1;
    @(negedge clk);
    wait_fall();
    for (int k = 0; k < 2; k++) begin
      measure(lo, hi, ra);
      chk({tag, " R2 low time"}, lo, exp_low(p, l));
      chk({tag, " R3 high time"}, hi, exp_high(p, h));
      chk({tag, " R4 rise_tick position"}, ra, 3);
      chk({tag, " R8 fall_tick at low start"}, int'(fall_tick), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int cnt, p, l, h, lo, hi, ra;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset drive", int'(scl_drive_low), 0);
    chk("R1 reset fault", int'(cfg_fault), 0);
    chk("R1 reset ticks", int'(rise_tick | fall_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cfg(0, 1, 1, "directed");
    run_cfg(7, 8, 8, "directed");
    run_cfg(1, 0, 0, "R9 zero counts");
    for (int i = 0; i < 10; i++) begin
      p = $urandom_range(0, 7); l = $urandom_range(1, 8); h = $urandom_range(1, 8);
      if (p == 2 && l == 2 && h == 2) h = 3;
      run_cfg(p, l, h, "random");
    end

    // R5 / R4: slave stretches the low phase
    run_cfg(1, 2, 2, "pre-stretch");
    wait_fall();
    other_low = 1'b1;
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cnt += int'(rise_tick);
    end
    chk("R5 no rise while stretched", cnt, 0);
    chk("R5 released own drive while waiting", int'(scl_drive_low), 0);
    chk("R5 line still low", int'(scl_line), 0);
    other_low = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 rise not before third edge", int'(rise_tick), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 rise after third edge", int'(rise_tick), 1);
    cnt = 0;
    while (scl_line && cnt < 5000) begin cnt++; @(negedge clk); end
    chk("R3 high after stretch", cnt, 2 * 2);

    // R6: another master pulls low during the high phase
    run_cfg(1, 3, 6, "pre-sync");
    wait_rise();
    repeat (2) @(negedge clk);
    other_low = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 no early fall_tick", int'(fall_tick), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 fall_tick after third edge", int'(fall_tick), 1);
    other_low = 1'b0;
    cnt = 0;
    while (scl_drive_low && cnt < 5000) begin cnt++; @(negedge clk); end
    chk("R6 restarted low drive length", cnt, 3 * 2);
    wait_fall();
    measure(lo, hi, ra);
    chk("R6 free run resumes low", lo, exp_low(1, 3));

    // R7: illegal combination
    en = 1'b0;
    @(negedge clk);
    psc = 8'd2; low_cnt = 8'd2; high_cnt = 8'd2;
    en = 1'b1;
    @(negedge clk);
    chk("R7 fault raised", int'(cfg_fault), 1);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cnt += int'(scl_drive_low) + int'(fall_tick);
    end
    chk("R7 never drives while faulted", cnt, 0);
    high_cnt = 8'd3;
    @(negedge clk);
    chk("R7 fault cleared", int'(cfg_fault), 0);
    chk("R7 starts low phase", int'(fall_tick), 1);

    // R1: disable mid-low
    wait_fall();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R1 disable releases", int'(scl_drive_low), 0);
    chk("R1 disable clears fault", int'(cfg_fault), 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt += int'(scl_drive_low) + int'(rise_tick) + int'(fall_tick);
    end
    chk("R1 stays idle when disabled", cnt, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule